// File: doc/BRIEF.md
# I2C Frame Service Router

This block sits between a byte-level I2C controller and a simple DMA engine. It decides, for every frame the byte engine completes, who services the next step of the message: the DMA engine, through a one-cycle request strobe, or the CPU, through a level interrupt that stays up until software acknowledges it. The routing depends on the operating role (master or slave, transmit or receive) and on where the frame falls in the message. Address frames, dummy frames and final frames go to the CPU or are handled as special cases. The data frames in the middle go to the DMA.

Software programs the role and a DMA frame count, then pulses `start`. A down-counter loaded from the count decrements on every DMA-routed frame. When it runs out, the block moves into the end handling for the role and then raises `done`.

The state machine has these states: `S_IDLE`, `S_HEAD` (waiting for the address frame), `S_HEAD_IRQ` (address frame with the CPU), `S_XFER` (DMA frames), `S_TAIL` / `S_TAIL_IRQ` (first end frame), `S_FINAL` / `S_FINAL_IRQ` (second end frame, master transmit only), `S_DRAIN` (slave transmit, dummy byte in flight, waiting for stop) and `S_DONE`.

Its transitions are:
- start accepted (IDLE/DONE → HEAD, XFER or the end phase)
- address frame seen (HEAD → HEAD_IRQ)
- address acknowledged (HEAD_IRQ → XFER, or the end phase when the count is zero)
- last DMA frame (XFER → TAIL or DRAIN)
- end frame seen (TAIL → TAIL_IRQ, FINAL → FINAL_IRQ)
- end acknowledged (TAIL_IRQ → FINAL or DONE, FINAL_IRQ → DONE)
- stop seen (DRAIN → DONE)

Top module: `i2c_xfer_router`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dma_req`, `cpu_irq` and `done` are all low and the block is idle.
- R2: In idle, `frame_done`, `stop_seen` and `cpu_ack` change no output; only `start` begins a message.
- R3: Master transmit (`mode`=0), count N: the first N frames after start each produce a DMA request. The next frame raises `cpu_irq`, which clears on ack. A further frame raises `cpu_irq` again, and its ack sets `done`.
- R4: Master receive (`mode`=1), count N: the first frame raises `cpu_irq`. After the ack, N frames produce DMA requests. One more frame raises `cpu_irq`, and its ack sets `done`.
- R5: Slave receive (`mode`=3) follows the same frame routing as R4: one CPU frame, then N DMA frames, then one CPU frame, then `done`.
- R6: Slave transmit (`mode`=2), count N: one CPU frame, then N DMA frames, the last being the dummy 0xFF byte. After that, frames raise neither a request nor an interrupt, and `stop_seen` sets `done`.
- R7: `dma_req` is high for exactly one cycle, in the cycle after each DMA-routed `frame_done`, once per such frame.
- R8: `cpu_irq` stays high until `cpu_ack`. Frames arriving while it is high are neither forwarded to the DMA nor counted.
- R9: A count of zero skips the DMA phase entirely.
- R10: `mode` and `count` are sampled only when a start is accepted. Later changes have no effect on the message in progress.
- R11: `done` stays high until the next start, which clears it and begins a new message.
- R12: A `start` pulse during a message is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a message (accepted in idle or done) |
| mode | input | 2 | 0 master tx, 1 master rx, 2 slave tx, 3 slave rx |
| count | input | CNT_W | DMA frame count |
| frame_done | input | 1 | One-cycle strobe: byte engine finished a frame |
| stop_seen | input | 1 | Stop condition detected on the bus |
| cpu_ack | input | 1 | CPU acknowledges the interrupt |
| dma_req | output | 1 | One-cycle DMA transfer request |
| cpu_irq | output | 1 | Level interrupt to the CPU |
| done | output | 1 | Message complete |

## Verification
On every cycle, the assertions check the following:
- a DMA request and a CPU interrupt are never raised together;
- a request only ever follows a frame strobe;
- the interrupt holds until acknowledged;
- `done` holds until a start;
- the idle state is left only by a start;
- the counter never steps below zero.

The order of frames within each role cannot be shown by a per-cycle property, and only the bench's scenarios demonstrate it: how many DMA frames come between the CPU frames, the two-step end of master transmit, and the stop-terminated drain of slave transmit. The same holds for the zero-count skip, the latching of mode and count, and ignored mid-message starts.

// File: rtl/i2c_route_pkg.sv
package i2c_route_pkg;

    typedef enum logic [1:0] {
        MODE_MTX = 2'd0,
        MODE_MRX = 2'd1,
        MODE_STX = 2'd2,
        MODE_SRX = 2'd3
    } xfer_mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HEAD,
        S_HEAD_IRQ,
        S_XFER,
        S_TAIL,
        S_TAIL_IRQ,
        S_FINAL,
        S_FINAL_IRQ,
        S_DRAIN,
        S_DONE
    } rt_state_e;

    typedef struct packed {
        logic       cpu_head;    // address frame handled by CPU
        logic [1:0] tail_frames; // CPU frames after the DMA phase
        logic       stop_ends;   // message closes on stop detection
    } mode_prof_t;

endpackage

// File: rtl/mode_profile.sv
module mode_profile
    import i2c_route_pkg::*;
(
    input  logic [1:0] mode,
    output mode_prof_t prof
);
    always_comb begin
        prof = '0;
        unique case (xfer_mode_e'(mode))
            MODE_MTX: begin prof.cpu_head = 1'b0; prof.tail_frames = 2'd2; prof.stop_ends = 1'b0; end
            MODE_MRX: begin prof.cpu_head = 1'b1; prof.tail_frames = 2'd1; prof.stop_ends = 1'b0; end
            MODE_STX: begin prof.cpu_head = 1'b1; prof.tail_frames = 2'd0; prof.stop_ends = 1'b1; end
            MODE_SRX: begin prof.cpu_head = 1'b1; prof.tail_frames = 2'd1; prof.stop_ends = 1'b0; end
        endcase
    end
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - ONE;
    end

    assign zero = (cnt_q == '0);
    assign last = (cnt_q == ONE);

    // R7: a DMA frame is only counted while frames remain
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        dec |-> !zero);
endmodule

// File: rtl/i2c_xfer_router.sv
module i2c_xfer_router
    import i2c_route_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] count,
    input  logic             frame_done,
    input  logic             stop_seen,
    input  logic             cpu_ack,
    output logic             dma_req,
    output logic             cpu_irq,
    output logic             done
);
    rt_state_e  state, nxt;
    logic [1:0] mode_q;
    logic [1:0] mode_sel;
    mode_prof_t prof;
    logic       at_rest, start_acc, dma_hit;
    logic       cnt_zero, cnt_last;
    rt_state_e  after_xfer;

    assign at_rest   = (state == S_IDLE) || (state == S_DONE);
    assign start_acc = start && at_rest;
    assign mode_sel  = at_rest ? mode : mode_q;
    assign dma_hit   = (state == S_XFER) && frame_done;

    mode_profile u_prof (
        .mode (mode_sel),
        .prof (prof)
    );

    xfer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start_acc),
        .load_val (count),
        .dec      (dma_hit),
        .zero     (cnt_zero),
        .last     (cnt_last)
    );

    always_comb begin
        if (prof.stop_ends)             after_xfer = S_DRAIN;
        else if (prof.tail_frames != 0) after_xfer = S_TAIL;
        else                            after_xfer = S_DONE;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_DONE: if (start) begin
                if (prof.cpu_head)     nxt = S_HEAD;
                else if (count == '0)  nxt = after_xfer;
                else                   nxt = S_XFER;
            end
            S_HEAD:      if (frame_done) nxt = S_HEAD_IRQ;
            S_HEAD_IRQ:  if (cpu_ack)    nxt = cnt_zero ? after_xfer : S_XFER;
            S_XFER:      if (frame_done && cnt_last) nxt = after_xfer;
            S_TAIL:      if (frame_done) nxt = S_TAIL_IRQ;
            S_TAIL_IRQ:  if (cpu_ack)    nxt = (prof.tail_frames == 2'd2) ? S_FINAL : S_DONE;
            S_FINAL:     if (frame_done) nxt = S_FINAL_IRQ;
            S_FINAL_IRQ: if (cpu_ack)    nxt = S_DONE;
            S_DRAIN:     if (stop_seen)  nxt = S_DONE;
            default:                     nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            mode_q <= '0;
        end else begin
            state <= nxt;
            if (start_acc) mode_q <= mode;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            dma_req <= 1'b0;
            cpu_irq <= 1'b0;
            done    <= 1'b0;
        end else begin
            dma_req <= dma_hit;
            cpu_irq <= (nxt == S_HEAD_IRQ) || (nxt == S_TAIL_IRQ) || (nxt == S_FINAL_IRQ);
            done    <= (nxt == S_DONE);
        end
    end

    // R7: a request only follows a frame strobe
    p_req_after_frame_r7: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> $past(frame_done));
    // R8: interrupt holds until acknowledged
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq && !cpu_ack) |=> cpu_irq);
    // R8: DMA and CPU never serve the same cycle
    p_req_irq_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(dma_req && cpu_irq));
    // R11: done holds until a start
    p_done_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    // R2: idle is left only by a start
    p_idle_stay_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !start) |=> (state == S_IDLE && !dma_req && !cpu_irq));
endmodule

// File: tb/test_i2c_xfer_router.sv
module test_i2c_xfer_router;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic [CNT_W-1:0] count = '0;
    logic             frame_done = 1'b0;
    logic             stop_seen = 1'b0;
    logic             cpu_ack = 1'b0;
    logic             dma_req, cpu_irq, done;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    i2c_xfer_router #(.CNT_W(CNT_W)) i_i2c_xfer_router (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .count(count),
        .frame_done(frame_done), .stop_seen(stop_seen), .cpu_ack(cpu_ack),
        .dma_req(dma_req), .cpu_irq(cpu_irq), .done(done)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {dma_req,cpu_irq,done} actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {dma_req, cpu_irq, done};
    endfunction

    task automatic do_start(input logic [1:0] m, input int n);
        @(negedge clk); start = 1'b1; mode = m; count = CNT_W'(n);
        @(negedge clk); start = 1'b0;
    endtask

    task automatic frame(input string tag, input logic [2:0] exp);
        frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        check(tag, outs(), exp);
    endtask

    task automatic ack(input string tag, input logic [2:0] exp);
        cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
        check(tag, outs(), exp);
    endtask

    task automatic t_reset();
        @(negedge clk); check("R1 in reset", outs(), 3'b000);
        rst = 1'b0;
        @(negedge clk); check("R1 after reset", outs(), 3'b000);
    endtask

    task automatic t_idle_ignore();
        frame("R2 idle frame", 3'b000);
        stop_seen = 1'b1; @(negedge clk); stop_seen = 1'b0;
        ack("R2 idle stop/ack", 3'b000);
    endtask

    task automatic t_mtx();
        do_start(2'd0, 3);
        check("R3 mtx started", outs(), 3'b000);
        for (int i = 0; i < 3; i++) begin
            frame("R3 mtx data frame", 3'b100);
            @(negedge clk); check("R7 request one cycle", outs(), 3'b000);
        end
        frame("R3 mtx first end frame", 3'b010);
        ack("R3 mtx first ack", 3'b000);
        frame("R3 mtx second end frame", 3'b010);
        ack("R3 mtx done", 3'b001);
    endtask

    task automatic t_mrx();
        do_start(2'd1, 2);
        check("R11 start clears done", outs(), 3'b000);
        mode = 2'd2; count = 8'd7; // R10: no effect mid-message
        frame("R4 mrx address frame", 3'b010);
        ack("R4 mrx address ack", 3'b000);
        frame("R4 mrx data 1", 3'b100);
        frame("R7 back-to-back request", 3'b100);
        frame("R10 mrx last frame to CPU", 3'b010);
        ack("R4 mrx done", 3'b001);
    endtask

    task automatic t_srx();
        do_start(2'd3, 1);
        frame("R5 srx address frame", 3'b010);
        repeat (3) @(negedge clk);
        check("R8 irq held", outs(), 3'b010);
        frame("R8 frame during irq ignored", 3'b010);
        ack("R5 srx address ack", 3'b000);
        frame("R5 srx data", 3'b100);
        frame("R5 srx last frame", 3'b010);
        ack("R5 srx done", 3'b001);
        repeat (4) @(negedge clk);
        check("R11 done held", outs(), 3'b001);
    endtask

    task automatic t_stx();
        do_start(2'd2, 2);
        frame("R6 stx address frame", 3'b010);
        ack("R6 stx address ack", 3'b000);
        frame("R6 stx data", 3'b100);
        frame("R6 stx dummy request", 3'b100);
        frame("R6 stx frame in drain ignored", 3'b000);
        stop_seen = 1'b1; @(negedge clk); stop_seen = 1'b0;
        check("R6 stx stop ends", outs(), 3'b001);
    endtask

    task automatic t_zero();
        do_start(2'd1, 0);
        frame("R9 zero address frame", 3'b010);
        ack("R9 zero ack", 3'b000);
        frame("R9 zero goes to CPU end", 3'b010);
        ack("R9 zero done", 3'b001);
    endtask

    task automatic t_busy_start();
        do_start(2'd0, 2);
        frame("R12 first data", 3'b100);
        do_start(2'd1, 5);
        check("R12 start ignored", outs(), 3'b000);
        frame("R12 second data", 3'b100);
        frame("R12 end after original count", 3'b010);
        ack("R12 ack", 3'b000);
        frame("R12 second end", 3'b010);
        ack("R12 done", 3'b001);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_idle_ignore();
        t_mtx();
        t_mrx();
        t_srx();
        t_stx();
        t_zero();
        t_busy_start();
        finish_run();
    end
endmodule